// File: doc/BRIEF.md
# Dual-Lane Serial ADC Capture Controller

This block is the host-side master for a sampling converter with two conversion channels. The converter returns each channel's result on its own serial data line. Both lines share one serial clock and one active-low chip select. The controller divides the system clock down to a serial clock and opens frames at evenly spaced instants. In each read frame it shifts both lanes in together and then hands back two 12-bit results, zero-extended to 16-bit words, with a one-cycle valid strobe.

The host drives the frame interval, the serial clock divider and the word length. The frame interval is set so that the spacing between samples stays fixed. Holding `sample_en` high keeps frames running. A pulse on `pd_req` asks for a truncated 8-clock frame, which the converter reads as a power-down command. If that pulse arrives while a frame is in progress, the request waits for the next frame slot.

Top module: `adc_dual_capture`

## Requirements
- R1: While `rst_n` is low, `adc_cs_n` and `adc_sclk` are 1, `busy` and `res_valid` are 0, and both result words are 0. This holds even if reset arrives in the middle of a frame.
- R2: The serial clock idles high whenever chip select is high. Inside a frame, each high and low phase lasts `cfg_div`+1 system clock cycles, so chip select stays low for 2·N·(`cfg_div`+1) cycles in an N-clock frame.
- R3: Both lanes are sampled together on every falling edge of `adc_sclk`, most significant bit first, within the same frame.
- R4: With `cfg_short`=0 a read frame has 16 serial clocks. Numbering the arrived bits from 1, the result MSB is bit 3 and the result LSB is bit 14.
- R5: With `cfg_short`=1 a read frame has 14 serial clocks. The result is taken from the same arrival positions, bits 3 to 14.
- R6: Each result is presented in a 16-bit word with the 12-bit value in bits [11:0]. Bits [15:12] are always 0.
- R7: `res_valid` is a one-cycle pulse in the first cycle in which `adc_cs_n` is high after a read frame. Both result words hold their value until the next pulse.
- R8: While `sample_en` is high, a frame starts every `cfg_period` system clock cycles, measured from one falling edge of `adc_cs_n` to the next. The first frame starts right away.
- R9: After a frame, chip select stays high for at least one full serial clock period (2·(`cfg_div`+1) cycles). A slot that arrives while a frame or this gap is still running is skipped.
- R10: A `pd_req` pulse causes the next slot to carry an 8-clock frame. That frame produces no `res_valid`. A request that arrives mid-frame waits until that frame has finished.
- R11: `busy` is high from the cycle `adc_cs_n` falls until the end of the post-frame gap.
- R12: `cfg_div` and `cfg_short` are captured when a frame opens. Changing them mid-frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | Keep periodic read frames running |
| pd_req | input | 1 | Pulse: request an 8-clock power-down frame |
| cfg_div | input | DIV_W | Serial clock half period minus one, in system cycles |
| cfg_period | input | PERIOD_W | Frame-to-frame interval in system cycles |
| cfg_short | input | 1 | 1 selects the 14-clock read frame |
| adc_sdata_a | input | 1 | Serial data from converter A |
| adc_sdata_b | input | 1 | Serial data from converter B |
| adc_cs_n | output | 1 | Active-low chip select |
| adc_sclk | output | 1 | Serial clock, idles high |
| busy | output | 1 | Frame or post-frame gap in progress |
| res_valid | output | 1 | One-cycle strobe: new results present |
| res_a | output | 16 | Lane A result, zero-filled |
| res_b | output | 16 | Lane B result, zero-filled |

## Verification
The bench walks words whose leading and trailing bits are ones, at several dividers and in both frame lengths. A design that took the result from the wrong offset, or that used the full-frame offset in a short frame, would therefore return visibly shifted values. It sets a frame interval shorter than a frame. A pacer that queued a missed slot, instead of skipping it, would produce uneven spacing. It raises a power-down request in the middle of a read frame, and changes the divider and the length mid-frame. Cutting the read short, strobing valid on the 8-clock frame, or re-timing the open frame would each show up as wrong clock counts or wrong chip-select durations. A reset asserted mid-frame must leave the select and clock high at once.

// File: rtl/adc_cap_pkg.sv
`timescale 1ns/1ps
package adc_cap_pkg;

  localparam int WORD_W     = 16;
  localparam int RES_W      = 12;
  localparam int LEAD_BITS  = 2;
  localparam int FULL_CLKS  = 16;
  localparam int SHORT_CLKS = 14;
  localparam int PD_CLKS    = 8;
  localparam int EDGE_W     = $clog2(2 * FULL_CLKS);

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_ACTIVE = 2'd1,
    SEQ_GAP    = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    FRM_FULL  = 2'd0,
    FRM_SHORT = 2'd1,
    FRM_PDOWN = 2'd2
  } frame_kind_e;

  // serial clocks in one frame of the given kind
  function automatic int frame_clocks(frame_kind_e kind);
    case (kind)
      FRM_SHORT: return SHORT_CLKS;
      FRM_PDOWN: return PD_CLKS;
      default:   return FULL_CLKS;
    endcase
  endfunction

  // index of the last half-period edge of a frame (a rising edge)
  function automatic logic [EDGE_W-1:0] last_edge_index(frame_kind_e kind);
    return EDGE_W'(2 * frame_clocks(kind) - 1);
  endfunction

  // bits that arrive after the result field
  function automatic int trail_bits(frame_kind_e kind);
    return frame_clocks(kind) - LEAD_BITS - RES_W;
  endfunction

  // pull the result field out of a right-aligned shift register
  function automatic logic [RES_W-1:0] extract_result(logic [WORD_W-1:0] sr,
                                                      frame_kind_e kind);
    logic [WORD_W-1:0] aligned;
    aligned = sr >> trail_bits(kind);
    return aligned[RES_W-1:0];
  endfunction

  // place a result in the low bits of a zeroed output word
  function automatic logic [WORD_W-1:0] zero_fill(logic [RES_W-1:0] res);
    return {{(WORD_W - RES_W){1'b0}}, res};
  endfunction

endpackage

// File: rtl/adc_cap_pacer.sv
`timescale 1ns/1ps
module adc_cap_pacer #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic [PERIOD_W-1:0] period,
  output logic                slot
);

  logic [PERIOD_W-1:0] cnt_q;
  logic [PERIOD_W:0]   cnt_inc;
  logic                wrap;

  assign cnt_inc = {1'b0, cnt_q} + (PERIOD_W+1)'(1);
  assign wrap    = cnt_inc >= {1'b0, period};
  assign slot    = run && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (wrap) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_inc[PERIOD_W-1:0];
    end
  end

endmodule

// File: rtl/adc_cap_seq.sv
`timescale 1ns/1ps
module adc_cap_seq
  import adc_cap_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot,
  input  logic             rd_en,
  input  logic             pd_pend,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_short,
  output logic             cs_n,
  output logic             sclk,
  output logic             busy,
  output logic             launch,
  output logic             launch_pd,
  output logic             fall_evt,
  output logic             frame_done,
  output frame_kind_e      kind
);

  seq_state_e        state_q;
  logic [DIV_W-1:0]  hc_q;
  logic [DIV_W-1:0]  div_q;
  logic [EDGE_W-1:0] ec_q;
  frame_kind_e       kind_q;
  frame_kind_e       kind_next;
  logic              cs_q;
  logic              sclk_q;
  logic              half_tick;
  logic              last_edge;

  assign launch    = slot && (state_q == SEQ_IDLE) && (pd_pend || rd_en);
  assign launch_pd = launch && pd_pend;
  assign kind_next = pd_pend ? FRM_PDOWN : (cfg_short ? FRM_SHORT : FRM_FULL);

  assign half_tick  = (state_q != SEQ_IDLE) && (hc_q == div_q);
  assign last_edge  = (ec_q == last_edge_index(kind_q));
  assign fall_evt   = (state_q == SEQ_ACTIVE) && half_tick && sclk_q;
  assign frame_done = (state_q == SEQ_ACTIVE) && half_tick && last_edge;

  assign cs_n = cs_q;
  assign sclk = sclk_q;
  assign busy = (state_q != SEQ_IDLE);
  assign kind = kind_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      hc_q    <= '0;
      div_q   <= '0;
      ec_q    <= '0;
      kind_q  <= FRM_FULL;
      cs_q    <= 1'b1;
      sclk_q  <= 1'b1;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (launch) begin
            state_q <= SEQ_ACTIVE;
            cs_q    <= 1'b0;
            hc_q    <= '0;
            ec_q    <= '0;
            div_q   <= cfg_div;
            kind_q  <= kind_next;
          end
        end
        SEQ_ACTIVE: begin
          if (half_tick) begin
            hc_q   <= '0;
            sclk_q <= ~sclk_q;
            if (last_edge) begin
              state_q <= SEQ_GAP;
              cs_q    <= 1'b1;
              ec_q    <= '0;
            end else begin
              ec_q <= ec_q + EDGE_W'(1);
            end
          end else begin
            hc_q <= hc_q + DIV_W'(1);
          end
        end
        SEQ_GAP: begin
          if (half_tick) begin
            hc_q <= '0;
            ec_q <= ec_q + EDGE_W'(1);
            if (ec_q == EDGE_W'(1)) begin
              state_q <= SEQ_IDLE;
            end
          end else begin
            hc_q <= hc_q + DIV_W'(1);
          end
        end
        default: begin
          state_q <= SEQ_IDLE;
          cs_q    <= 1'b1;
          sclk_q  <= 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/adc_cap_lane.sv
`timescale 1ns/1ps
module adc_cap_lane
  import adc_cap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              fall_evt,
  input  logic              frame_done,
  input  frame_kind_e       kind,
  input  logic              sdata,
  output logic [WORD_W-1:0] result
);

  logic [WORD_W-1:0] sr_q;
  logic [WORD_W-1:0] res_q;

  assign result = res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (launch) begin
      sr_q <= '0;
    end else if (fall_evt) begin
      sr_q <= {sr_q[WORD_W-2:0], sdata};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (frame_done && (kind != FRM_PDOWN)) begin
      res_q <= zero_fill(extract_result(sr_q, kind));
    end
  end

endmodule

// File: rtl/adc_dual_capture.sv
`timescale 1ns/1ps
module adc_dual_capture
  import adc_cap_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_en,
  input  logic                pd_req,
  input  logic [DIV_W-1:0]    cfg_div,
  input  logic [PERIOD_W-1:0] cfg_period,
  input  logic                cfg_short,
  input  logic                adc_sdata_a,
  input  logic                adc_sdata_b,
  output logic                adc_cs_n,
  output logic                adc_sclk,
  output logic                busy,
  output logic                res_valid,
  output logic [15:0]         res_a,
  output logic [15:0]         res_b
);

  localparam int LANES = 2;

  logic              pd_pend;
  logic              pace_run;
  logic              slot;
  logic              launch;
  logic              launch_pd;
  logic              fall_evt;
  logic              frame_done;
  logic              frame_is_pd;
  logic              valid_q;
  frame_kind_e       kind;
  logic [LANES-1:0]  lane_din;
  logic [WORD_W-1:0] lane_res [LANES];

  assign pace_run    = sample_en || pd_pend;
  assign frame_is_pd = (kind == FRM_PDOWN);
  assign lane_din    = {adc_sdata_b, adc_sdata_a};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_pend <= 1'b0;
    end else begin
      pd_pend <= (pd_pend && !launch_pd) || pd_req;
    end
  end

  adc_cap_pacer #(.PERIOD_W(PERIOD_W)) u_pacer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (pace_run),
    .period (cfg_period),
    .slot   (slot)
  );

  adc_cap_seq #(.DIV_W(DIV_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot       (slot),
    .rd_en      (sample_en),
    .pd_pend    (pd_pend),
    .cfg_div    (cfg_div),
    .cfg_short  (cfg_short),
    .cs_n       (adc_cs_n),
    .sclk       (adc_sclk),
    .busy       (busy),
    .launch     (launch),
    .launch_pd  (launch_pd),
    .fall_evt   (fall_evt),
    .frame_done (frame_done),
    .kind       (kind)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    adc_cap_lane u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .launch     (launch),
      .fall_evt   (fall_evt),
      .frame_done (frame_done),
      .kind       (kind),
      .sdata      (lane_din[g]),
      .result     (lane_res[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= frame_done && !frame_is_pd;
    end
  end

  assign res_valid = valid_q;
  assign res_a     = lane_res[0];
  assign res_b     = lane_res[1];

endmodule

// File: rtl/adc_dual_capture_chk.sv
`timescale 1ns/1ps
module adc_dual_capture_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        adc_cs_n,
  input logic        adc_sclk,
  input logic        busy,
  input logic        res_valid,
  input logic [15:0] res_a,
  input logic [15:0] res_b,
  input logic        fall_evt,
  input logic        frame_done,
  input logic        frame_is_pd,
  input logic        pd_pend
);

  p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> adc_sclk);

  p_sample_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> (!adc_sclk && !adc_cs_n));

  p_zero_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_a[15:12] == 4'h0 && res_b[15:12] == 4'h0));

  p_valid_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (adc_cs_n && $past(!adc_cs_n)));

  p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  p_results_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(res_a) && $stable(res_b)));

  p_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_cs_n) |=> adc_cs_n);

  p_pd_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && frame_is_pd) |=> !res_valid);

  p_pd_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_pend && busy) |=> pd_pend);

  p_busy_cover_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_cs_n |-> busy);

endmodule

bind adc_dual_capture adc_dual_capture_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .adc_cs_n    (adc_cs_n),
  .adc_sclk    (adc_sclk),
  .busy        (busy),
  .res_valid   (res_valid),
  .res_a       (res_a),
  .res_b       (res_b),
  .fall_evt    (fall_evt),
  .frame_done  (frame_done),
  .frame_is_pd (frame_is_pd),
  .pd_pend     (pd_pend)
);

// File: tb/adc_dual_capture_tb.sv
`timescale 1ns/1ps
module adc_dual_capture_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sample_en;
  logic        pd_req;
  logic [7:0]  cfg_div;
  logic [15:0] cfg_period;
  logic        cfg_short;
  logic        sd_a = 1'b0;
  logic        sd_b = 1'b0;
  logic        adc_cs_n;
  logic        adc_sclk;
  logic        busy;
  logic        res_valid;
  logic [15:0] res_a;
  logic [15:0] res_b;

  always #4 clk = ~clk;

  adc_dual_capture u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_en   (sample_en),
    .pd_req      (pd_req),
    .cfg_div     (cfg_div),
    .cfg_period  (cfg_period),
    .cfg_short   (cfg_short),
    .adc_sdata_a (sd_a),
    .adc_sdata_b (sd_b),
    .adc_cs_n    (adc_cs_n),
    .adc_sclk    (adc_sclk),
    .busy        (busy),
    .res_valid   (res_valid),
    .res_a       (res_a),
    .res_b       (res_b)
  );

  // {div[3:0], 3'b0, short, word_a, word_b}
  localparam logic [39:0] VECS [6] = '{
    {4'd0, 3'd0, 1'b0, 16'h1234, 16'hABCD},
    {4'd1, 3'd0, 1'b0, 16'hFFFF, 16'h0000},
    {4'd2, 3'd0, 1'b1, 16'h0FFC, 16'h3003},
    {4'd0, 3'd0, 1'b1, 16'hC001, 16'h5A5A},
    {4'd3, 3'd0, 1'b0, 16'h2AA8, 16'hD554},
    {4'd1, 3'd0, 1'b1, 16'hFFFF, 16'h8001}
  };

  int checks = 0;
  int failures = 0;

  // bench-side converter model and frame monitor
  logic [15:0] cur_a = '0;
  logic [15:0] cur_b = '0;
  int  idx = 15;
  bit  prev_cs = 1'b1, prev_sclk = 1'b1, prev_busy = 1'b0;
  int  falls = 0, last_falls = 0, low_cnt = 0, last_low = 0;
  int  gap_cnt = 0, last_gap = 0, vcount = 0, nframes = 0;
  longint cyc = 0, fall_cyc = 0, last_space = 0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (prev_cs && !adc_cs_n) begin
      falls = 0;
      low_cnt = 0;
      if (nframes > 0) last_space = cyc - fall_cyc;
      fall_cyc = cyc;
      nframes = nframes + 1;
      idx = 15;
      sd_a = cur_a[15];
      sd_b = cur_b[15];
    end else if (!adc_cs_n && !prev_sclk && adc_sclk) begin
      idx = idx - 1;
      sd_a = (idx >= 0) ? cur_a[idx] : 1'b0;
      sd_b = (idx >= 0) ? cur_b[idx] : 1'b0;
    end
    if (!adc_cs_n && prev_sclk && !adc_sclk) falls = falls + 1;
    if (!adc_cs_n) low_cnt = low_cnt + 1;
    if (!prev_cs && adc_cs_n) begin
      last_falls = falls;
      last_low = low_cnt;
      gap_cnt = 0;
    end
    if (adc_cs_n && busy) gap_cnt = gap_cnt + 1;
    if (prev_busy && !busy) last_gap = gap_cnt;
    if (res_valid) vcount = vcount + 1;
    prev_cs = adc_cs_n;
    prev_sclk = adc_sclk;
    prev_busy = busy;
  end

  task automatic check_eq(input string req, input string what,
                          input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(logic [15:0] w);
    return {4'h0, w[13:2]};
  endfunction

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_read(input int div, input bit sh,
                          input logic [15:0] wa, input logic [15:0] wb);
    int v0, n, h;
    n = sh ? 14 : 16;
    h = div + 1;
    cur_a = wa;
    cur_b = wb;
    cfg_div = 8'(div);
    cfg_short = sh;
    cfg_period = 16'd400;
    v0 = vcount;
    sample_en = 1'b1;
    while (vcount == v0) @(negedge clk);
    sample_en = 1'b0;
    wait_idle();
    check_eq(sh ? "R5" : "R4", "lane A result", res_a, exp_word(wa));
    check_eq("R3", "lane B result", res_b, exp_word(wb));
    check_eq("R6", "upper bits A|B", {res_a[15:12], res_b[15:12]}, 0);
    check_eq(sh ? "R5" : "R4", "falling edges", last_falls, n);
    check_eq("R2", "select low cycles", last_low, 2 * n * h);
    check_eq("R9", "post-frame gap", last_gap, 2 * h);
    check_eq("R7", "valid pulses", vcount - v0, 1);
  endtask

  task automatic run_spacing(input int period, input int exp_space,
                             input string req);
    int n0;
    cfg_div = 8'd0;
    cfg_short = 1'b0;
    cfg_period = 16'(period);
    cur_a = 16'h5555;
    cur_b = 16'hAAAA;
    n0 = nframes;
    sample_en = 1'b1;
    while (nframes < n0 + 3) @(negedge clk);
    sample_en = 1'b0;
    check_eq(req, "frame spacing", last_space, exp_space);
    wait_idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog all cycles=%0d expected<150000", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] hold_a, hold_b;
    int v0, n0;
    rst_n = 1'b0;
    sample_en = 1'b0;
    pd_req = 1'b0;
    cfg_div = 8'd0;
    cfg_period = 16'd400;
    cfg_short = 1'b0;
    repeat (5) @(negedge clk);
    check_eq("R1", "cs_n in reset", adc_cs_n, 1);
    check_eq("R1", "sclk in reset", adc_sclk, 1);
    check_eq("R1", "busy in reset", busy, 0);
    check_eq("R1", "valid in reset", res_valid, 0);
    check_eq("R1", "results in reset", {res_a, res_b}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // table of read frames
    for (int i = 0; i < 6; i++) begin
      run_read(int'(VECS[i][39:36]), VECS[i][32], VECS[i][31:16], VECS[i][15:0]);
    end

    // R8: equidistant frames; R9: slot that falls inside a frame is skipped
    run_spacing(60, 60, "R8");
    run_spacing(20, 40, "R9");
    check_eq("R9", "gap at div 0", last_gap, 2);

    // R10: power-down frame while idle
    hold_a = res_a;
    hold_b = res_b;
    cfg_div = 8'd0;
    v0 = vcount;
    n0 = nframes;
    pd_req = 1'b1;
    @(negedge clk);
    pd_req = 1'b0;
    while (nframes < n0 + 1) @(negedge clk);
    wait_idle();
    check_eq("R10", "pd frame edges", last_falls, 8);
    check_eq("R10", "pd select low cycles", last_low, 16);
    check_eq("R10", "no valid on pd", vcount - v0, 0);
    check_eq("R7", "results held A", res_a, hold_a);
    check_eq("R7", "results held B", res_b, hold_b);

    // R10: request raised mid-frame waits for the next slot
    cfg_div = 8'd1;
    cfg_short = 1'b0;
    cfg_period = 16'd200;
    cur_a = 16'h3C3C;
    cur_b = 16'h0FF0;
    v0 = vcount;
    n0 = nframes;
    sample_en = 1'b1;
    while (nframes < n0 + 1) @(negedge clk);
    repeat (10) @(negedge clk);
    pd_req = 1'b1;
    @(negedge clk);
    pd_req = 1'b0;
    while (vcount == v0) @(negedge clk);
    repeat (2) @(negedge clk);
    check_eq("R10", "read frame completes", last_falls, 16);
    check_eq("R10", "read result kept", res_a, exp_word(16'h3C3C));
    while (nframes < n0 + 2) @(negedge clk);
    while (!adc_cs_n) @(negedge clk);
    sample_en = 1'b0;
    wait_idle();
    check_eq("R10", "deferred pd edges", last_falls, 8);
    check_eq("R10", "valid count after pd", vcount - v0, 1);
    check_eq("R8", "pd frame on slot", last_space, 200);

    // R11: busy rises with the select
    cfg_div = 8'd0;
    cfg_period = 16'd400;
    sample_en = 1'b1;
    while (adc_cs_n) @(negedge clk);
    check_eq("R11", "busy with select low", busy, 1);
    sample_en = 1'b0;
    wait_idle();

    // R12: mid-frame config change ignored
    cfg_div = 8'd1;
    cfg_short = 1'b0;
    cur_a = 16'h7FFE;
    cur_b = 16'h1001;
    v0 = vcount;
    n0 = nframes;
    sample_en = 1'b1;
    while (nframes < n0 + 1) @(negedge clk);
    repeat (5) @(negedge clk);
    cfg_div = 8'd3;
    cfg_short = 1'b1;
    while (vcount == v0) @(negedge clk);
    sample_en = 1'b0;
    wait_idle();
    check_eq("R12", "select low cycles", last_low, 64);
    check_eq("R12", "edges kept at 16", last_falls, 16);
    check_eq("R12", "result offset kept", res_b, exp_word(16'h1001));

    // R1: reset during a frame
    cfg_div = 8'd3;
    sample_en = 1'b1;
    n0 = nframes;
    while (nframes < n0 + 1) @(negedge clk);
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_eq("R1", "cs_n after mid reset", adc_cs_n, 1);
    check_eq("R1", "sclk after mid reset", adc_sclk, 1);
    check_eq("R1", "busy after mid reset", busy, 0);
    check_eq("R1", "results after mid reset", {res_a, res_b}, 0);
    sample_en = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule